// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block combines 32 level-sensitive interrupt sources into two request lines, a normal request (`irqOut`) and a fast request (`fiqOut`). Each line has its own enable mask over the same set of raw sources, so one source can drive either line, both lines or neither. Software changes a mask only through a pair of addresses: one ORs the written ones into the mask and the other clears the bits written as one. Source 0 can also be raised and dropped by software, which allows a software-triggered interrupt and a self-test of the path.

Software reaches the registers through a word-addressed bus with one select, one write strobe and registered read data. Each line offers a raw view, a masked view and an enable readback. Controllers can be chained by wiring the `irqOut` of one instance to a source input of another.

Top module: `dual_intc`

## Requirements
- R1: After reset, both enable masks and the software bit are zero, `irqOut` and `fiqOut` are low and `busRdata` is zero.
- R2: Reading word 1 or word 9 returns the raw vector: bit n equals `srcIn[n]` for n ≥ 1, and bit 0 is `srcIn[0]` OR the software bit.
- R3: A write to word 2 ORs `busWdata` into the normal-request enable mask, and a read of word 2 returns that mask.
- R4: A write to word 3 clears each normal-request enable bit whose `busWdata` bit is 1 and leaves the other bits unchanged.
- R5: A write to word 10 ORs `busWdata` into the fast-request enable mask and a write to word 11 clears the bits written as 1. A read of word 10 returns that mask.
- R6: Reading word 0 returns raw AND normal-request enable, and reading word 8 returns raw AND fast-request enable.
- R7: A write to word 4 with `busWdata[0]`=1 sets the software bit and a write to word 5 with `busWdata[0]`=1 clears it. With `busWdata[0]`=0 neither write has an effect. A read of word 4 returns raw bit 0 in bit 0 and zero in bits 31:1.
- R8: Clearing the software bit does not clear raw bit 0 while `srcIn[0]` is high.
- R9: `irqOut` is the OR of raw AND normal-request enable, and `fiqOut` is the OR of raw AND fast-request enable, each computed on its own. Both are registered and follow a change of a source or a mask one clock later.
- R10: Reads of words 3, 5 and 11 and of all words that have no register (6, 7 and 12 and above) return zero.
- R11: Writes to words 0, 1, 8 and 9 change no mask and do not change the software bit.
- R12: `busRdata` is loaded on the clock edge that samples `busSel`=1 with `busWr`=0 and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 32 | Level interrupt sources |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Read data is due one edge after the read strobe. A source change reaches the request lines one edge after it is applied. A mask or software-bit write reaches them two edges after the access: one edge to load the register and one edge to register the output. The bench drives inputs on falling edges. It samples read data one falling edge after the strobe, samples the request lines one falling edge after a source change and two falling edges after a write, and computes each expected value from its own model of the masks and the software bit.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;

  // Channel indices: the normal request is bank 0, the fast request bank 1.
  localparam int NUM_CH = 2;
  localparam int CH_IRQ = 0;
  localparam int CH_FIQ = 1;

  // Word offsets inside a bank (bank picked by word address bit 3).
  localparam int OFS_MASKED = 0;
  localparam int OFS_RAW    = 1;
  localparam int OFS_ENSET  = 2;
  localparam int OFS_ENCLR  = 3;
  localparam int OFS_SWSET  = 4;
  localparam int OFS_SWCLR  = 5;

  typedef enum logic [2:0] {
    RD_ZERO   = 3'd0,
    RD_RAW    = 3'd1,
    RD_MASKED = 3'd2,
    RD_ENABLE = 3'd3,
    RD_SRC0   = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] enSet;
    logic [NUM_CH-1:0] enClr;
    logic              swSet;
    logic              swClr;
    logic              rdStb;
    rdSel_e            rdSel;
    logic              rdCh;
  } ctlStrobes_t;

endpackage

// File: rtl/dual_intc_ctrl.sv
module dual_intc_ctrl
  import dual_intc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wdBit0,
  output ctlStrobes_t       strobes
);

  localparam int OFS_W = 3;

  logic             inRange;
  logic             bankSel;
  logic [OFS_W-1:0] ofs;
  logic             doWrite;
  logic             doRead;

  always_comb begin
    inRange = ((busAddr >> 4) == '0);
    bankSel = busAddr[3];
    ofs     = busAddr[OFS_W-1:0];
    doWrite = busSel && busWr && inRange;
    doRead  = busSel && !busWr;
  end

  // Enable set and clear strobes, one pair per bank.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_enStb
    always_comb begin
      strobes.enSet[ch] = doWrite && (bankSel == 1'(ch)) && (ofs == OFS_W'(OFS_ENSET));
      strobes.enClr[ch] = doWrite && (bankSel == 1'(ch)) && (ofs == OFS_W'(OFS_ENCLR));
    end
  end

  // Software bit lives in bank 0 only and acts on data bit 0.
  always_comb begin
    strobes.swSet = doWrite && !bankSel && (ofs == OFS_W'(OFS_SWSET)) && wdBit0;
    strobes.swClr = doWrite && !bankSel && (ofs == OFS_W'(OFS_SWCLR)) && wdBit0;
  end

  // Read selection.
  always_comb begin
    strobes.rdStb = doRead;
    strobes.rdCh  = bankSel;
    strobes.rdSel = RD_ZERO;
    if (inRange) begin
      unique case (ofs)
        OFS_W'(OFS_MASKED): strobes.rdSel = RD_MASKED;
        OFS_W'(OFS_RAW):    strobes.rdSel = RD_RAW;
        OFS_W'(OFS_ENSET):  strobes.rdSel = RD_ENABLE;
        OFS_W'(OFS_SWSET):  strobes.rdSel = bankSel ? RD_ZERO : RD_SRC0;
        default:            strobes.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/dual_intc_dp.sv
module dual_intc_dp
  import dual_intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  srcIn,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              fiqOut
);

  logic              swBit;
  logic [N_SRC-1:0]  rawVec;
  logic [N_SRC-1:0]  enMask  [NUM_CH];
  logic [N_SRC-1:0]  masked  [NUM_CH];
  logic [NUM_CH-1:0] reqReg;
  logic [DATA_W-1:0] rdNext;

  // Software-held bit merged into source 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                swBit <= 1'b0;
    else if (strobes.swSet)   swBit <= 1'b1;
    else if (strobes.swClr)   swBit <= 1'b0;
  end

  always_comb begin
    rawVec    = srcIn;
    rawVec[0] = srcIn[0] | swBit;
  end

  // One enable mask and one registered request per channel.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enMask[ch] <= '0;
      end else if (strobes.enSet[ch]) begin
        enMask[ch] <= enMask[ch] | busWdata[N_SRC-1:0];
      end else if (strobes.enClr[ch]) begin
        enMask[ch] <= enMask[ch] & ~busWdata[N_SRC-1:0];
      end
    end

    assign masked[ch] = rawVec & enMask[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) reqReg[ch] <= 1'b0;
      else       reqReg[ch] <= |masked[ch];
    end
  end

  assign irqOut = reqReg[CH_IRQ];
  assign fiqOut = reqReg[CH_FIQ];

  // Read data selection and register.
  always_comb begin
    rdNext = '0;
    unique case (strobes.rdSel)
      RD_RAW:    rdNext[N_SRC-1:0] = rawVec;
      RD_MASKED: rdNext[N_SRC-1:0] = masked[strobes.rdCh];
      RD_ENABLE: rdNext[N_SRC-1:0] = enMask[strobes.rdCh];
      RD_SRC0:   rdNext[0]         = rawVec[0];
      default:   rdNext            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busRdata <= '0;
    else if (strobes.rdStb) busRdata <= rdNext;
  end

endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import dual_intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  srcIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              fiqOut
);

  ctlStrobes_t strobes;

  dual_intc_ctrl #(
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .wdBit0  (busWdata[0]),
    .strobes (strobes)
  );

  dual_intc_dp #(
    .N_SRC  (N_SRC),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .strobes  (strobes),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );

endmodule

// File: rtl/dual_intc_chk.sv
module dual_intc_chk #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [N_SRC-1:0]  srcIn,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              fiqOut
);

  logic isRead;
  assign isRead = busSel && !busWr;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> $stable(busRdata)); // R12

  AST_WO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    isRead && (busAddr == ADDR_W'(3) || busAddr == ADDR_W'(5) || busAddr == ADDR_W'(11))
    |=> busRdata == '0); // R10

  AST_RAW_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    isRead && (busAddr == ADDR_W'(1) || busAddr == ADDR_W'(9))
    |=> busRdata[N_SRC-1:1] == $past(srcIn[N_SRC-1:1])); // R2

  AST_SRC0_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    isRead && busAddr == ADDR_W'(4) |=> busRdata[DATA_W-1:1] == '0); // R7

  AST_HW0_WINS: assert property (@(posedge clk) disable iff (!rstN)
    isRead && busAddr == ADDR_W'(1) && srcIn[0] |=> busRdata[0]); // R8

endmodule

bind dual_intc dual_intc_chk #(
  .N_SRC  (N_SRC),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk_i (.*);

// File: tb/dual_intc_tb_top.sv
`timescale 1ns/1ps
module dual_intc_tb_top;

  localparam int N_SRC  = 32;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int WATCHDOG_CYC = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [N_SRC-1:0]  srcIn = '0;
  logic              busSel = 1'b0;
  logic              busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              irqOut;
  logic              fiqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench model
  logic [N_SRC-1:0] mIrqEn = '0;
  logic [N_SRC-1:0] mFiqEn = '0;
  logic             mSw    = 1'b0;

  always #4 clk = ~clk;

  dual_intc #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic logic [N_SRC-1:0] mRaw();
    logic [N_SRC-1:0] r;
    r = srcIn;
    r[0] = srcIn[0] | mSw;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] expRead(input int a);
    logic [N_SRC-1:0] r;
    r = mRaw();
    case (a)
      0:  return r & mIrqEn;
      1:  return r;
      2:  return mIrqEn;
      4:  return {31'd0, r[0]};
      8:  return r & mFiqEn;
      9:  return r;
      10: return mFiqEn;
      default: return '0;
    endcase
  endfunction

  function automatic void mWrite(input int a, input logic [DATA_W-1:0] d);
    case (a)
      2:  mIrqEn = mIrqEn | d;
      3:  mIrqEn = mIrqEn & ~d;
      4:  if (d[0]) mSw = 1'b1;
      5:  if (d[0]) mSw = 1'b0;
      10: mFiqEn = mFiqEn | d;
      11: mFiqEn = mFiqEn & ~d;
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string req);
    check(req, {31'd0, irqOut}, {31'd0, |(mRaw() & mIrqEn)});
    check(req, {31'd0, fiqOut}, {31'd0, |(mRaw() & mFiqEn)});
  endtask

  task automatic busWrite(input int a, input logic [DATA_W-1:0] d, input string req);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    mWrite(a, d);
    @(negedge clk);
    checkOuts(req);
  endtask

  task automatic busRead(input int a, input string req);
    logic [DATA_W-1:0] e;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = ADDR_W'(a);
    e = expRead(a);
    @(negedge clk);
    busSel = 1'b0;
    check(req, busRdata, e);
  endtask

  task automatic setSrc(input logic [N_SRC-1:0] v, input string req);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
    checkOuts(req);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", busRdata, '0);
    checkOuts("R1 outputs");
    rstN = 1'b1;
    @(negedge clk);
    checkOuts("R1 after release");
    busRead(2, "R1 irq mask");
    busRead(10, "R1 fiq mask");

    // R2 / R9: raw mirror and output independence
    setSrc(32'h0000_0120, "R9 no enables");
    busRead(1, "R2 raw word1");
    busRead(9, "R2 raw word9");
    busWrite(2, 32'h0000_0020, "R9 irq only");
    check("R9 irq high", {31'd0, irqOut}, 32'd1);
    check("R9 fiq low", {31'd0, fiqOut}, 32'd0);
    busRead(2, "R3 readback");
    busWrite(10, 32'h0000_0100, "R5 fiq set");
    busRead(10, "R5 readback");
    busRead(0, "R6 irq masked");
    busRead(8, "R6 fiq masked");
    busWrite(3, 32'hFFFF_FFDF, "R4 clear others");
    busRead(2, "R4 bit kept");
    busWrite(3, 32'h0000_0020, "R4 clear bit");
    busWrite(11, 32'h0000_0100, "R5 fiq clear");

    // R11: writes to read-only words
    busWrite(0, 32'hFFFF_FFFF, "R11 word0");
    busWrite(1, 32'hFFFF_FFFF, "R11 word1");
    busWrite(8, 32'hFFFF_FFFF, "R11 word8");
    busWrite(9, 32'hFFFF_FFFF, "R11 word9");
    busRead(2, "R11 irq mask");
    busRead(10, "R11 fiq mask");
    busRead(4, "R11 soft bit");

    // R7 / R8: software bit
    setSrc('0, "R7 quiet");
    busWrite(2, 32'h1, "R7 en0");
    busWrite(4, 32'h2, "R7 set bit0 low");
    busRead(4, "R7 no set");
    busWrite(4, 32'h1, "R7 set");
    check("R7 irq via soft", {31'd0, irqOut}, 32'd1);
    busRead(4, "R7 read word4");
    busWrite(5, 32'hFFFF_FFFE, "R7 clr bit0 low");
    busRead(4, "R7 still set");
    busWrite(5, 32'h1, "R7 clear");
    setSrc(32'h1, "R8 hw0 high");
    busWrite(4, 32'h1, "R8 set");
    busWrite(5, 32'h1, "R8 clr with hw high");
    busRead(1, "R8 raw bit0");
    check("R8 irq stays", {31'd0, irqOut}, 32'd1);

    // R10: zero words
    for (int a = 0; a < 16; a++)
      if (a == 3 || a == 5 || a == 6 || a == 7 || a >= 11)
        busRead(a, "R10 zero word");

    // R12: read data holds
    busRead(1, "R12 load");
    held = busRdata;
    setSrc(32'hA5A5_0000, "R12 src change");
    busWrite(2, 32'hFFFF_FFFF, "R12 write");
    check("R12 held", busRdata, held);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      int a;
      logic [DATA_W-1:0] d;
      op = int'($urandom_range(0, 2));
      a  = int'($urandom_range(0, 15));
      d  = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & 32'h0000_0003;
      case (op)
        0: setSrc(d & $urandom(), "R9 random src");
        1: busWrite(a, d, "R3 R5 random write");
        default: busRead(a, "R6 random read");
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule